// File: doc/BRIEF.md
# Matrix keypad scanning decoder

This block finds which key of a 4x4 matrix keypad is pressed and returns it as a 4-bit hexadecimal code. It selects one row line at a time by pulling it low. The other three rows are left floating. It reads the four column lines, which have external pull-ups. A pressed key on the selected row therefore reads as a 0 on its column. Because only the selected row is ever driven, two keys pressed in the same column cannot short two driven rows together.

The scan does not run on every clock. It moves forward only on cycles where a one-cycle `scan_en` pulse is present. That pulse comes from a slow tick source of about 200 Hz. When a key is seen, the scan stops on that row, the code is latched and `key_valid` goes high. The block then waits until the keypad has read idle for two pulses in a row. After that it clears `key_valid` and scans again. Each row pad is built as an open-drain driver: when its `row_oe` bit is high the pad drives 0, and when the bit is low the pad is high-impedance.

Top module: `keypad_scanner`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `row_oe` = 4'b0001, `key_code` = 0 and `key_valid` = 0. Reset is synchronous and active-high.
- R2: Exactly one bit of `row_oe` is high at all times. Bit i enables the low drive on row i, and every row whose bit is low is released.
- R3: `row_oe`, `key_code` and `key_valid` change only on the clock edge that follows a cycle with `scan_en` high.
- R4: While `key_valid` is low and `col_n` reads 4'hF on a pulse, the selected row advances 0, 1, 2, 3, 0, ... one step per pulse.
- R5: While `key_valid` is low, a pulse with any `col_n` bit at 0 sets `key_valid` on the next edge. On that same edge the row stays where it is and `key_code` is loaded.
- R6: The loaded code depends on the row r and the column c, where column c is `col_n[c]`. Row 0 gives 1,2,3,A for columns 0 to 3. Row 1 gives 4,5,6,B. Row 2 gives 7,8,9,C. Row 3 gives E,0,F,D.
- R7: If several `col_n` bits are 0 on the capturing pulse, the lowest-numbered column is the one encoded.
- R8: While `key_valid` is high, the selected row and `key_code` stay fixed, and further key presses do not change them.
- R9: While `key_valid` is high, `key_valid` clears on the second of two consecutive pulses on which `col_n` reads 4'hF. A pulse with a 0 column in between restarts the count. After `key_valid` clears, scanning resumes from the row that was held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | One-cycle enable pulse that steps the scan |
| col_n | input | 4 | Column lines, active low, externally pulled up |
| row_oe | output | 4 | Per-row low-drive enable; a low bit means that row is high-impedance |
| key_code | output | 4 | Latched hexadecimal key code |
| key_valid | output | 1 | High while a captured key is held |

## Verification
Two functions can fall on the same pulse: the release count finishing and a new key press. Suppose the first idle pulse has been seen and a bounce then pulls a column low on the very next pulse. The bench creates this case on purpose. It expects `key_valid` to stay high and the count to start over, and it expects the release to finish only after two fresh idle pulses. The same case also occurs under the random press patterns, where a second key can arrive on any pulse during release. Every pulse is compared against a reference model of the scan, so a release that completes too early, or a capture that happens twice, shows up at once on `key_valid`, `row_oe` or `key_code`.

// File: rtl/keypad_scanner.sv
module keypad_scanner (
  input  logic       clk,
  input  logic       rst,
  input  logic       scan_en,
  input  logic [3:0] col_n,
  output logic [3:0] row_oe,
  output logic [3:0] key_code,
  output logic       key_valid
);
  logic [1:0] row_q;
  logic       hold_q;
  logic       idle_seen_q;
  logic [3:0] code_q;
  logic [1:0] col_sel;
  logic       hit;

  function automatic logic [3:0] key_map(input logic [1:0] r, input logic [1:0] c);
    logic [3:0] v;
    case ({r, c})
      4'h0: v = 4'h1;  4'h1: v = 4'h2;  4'h2: v = 4'h3;  4'h3: v = 4'hA;
      4'h4: v = 4'h4;  4'h5: v = 4'h5;  4'h6: v = 4'h6;  4'h7: v = 4'hB;
      4'h8: v = 4'h7;  4'h9: v = 4'h8;  4'hA: v = 4'h9;  4'hB: v = 4'hC;
      4'hC: v = 4'hE;  4'hD: v = 4'h0;  4'hE: v = 4'hF;  default: v = 4'hD;
    endcase
    return v;
  endfunction

  assign hit = (col_n != 4'hF);

  always_comb begin
    col_sel = 2'd3;
    for (int i = 3; i >= 0; i--)
      if (!col_n[i]) col_sel = 2'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q       <= '0;
      hold_q      <= 1'b0;
      idle_seen_q <= 1'b0;
      code_q      <= '0;
    end else if (scan_en) begin
      if (!hold_q) begin
        if (hit) begin
          hold_q      <= 1'b1;
          idle_seen_q <= 1'b0;
          code_q      <= key_map(row_q, col_sel);
        end else begin
          row_q <= row_q + 2'd1;
        end
      end else if (hit) begin
        idle_seen_q <= 1'b0;
      end else if (idle_seen_q) begin
        hold_q      <= 1'b0;
        idle_seen_q <= 1'b0;
      end else begin
        idle_seen_q <= 1'b1;
      end
    end
  end

  assign row_oe    = 4'b0001 << row_q;
  assign key_code  = code_q;
  assign key_valid = hold_q;
endmodule

module keypad_scanner_chk (
  input logic       clk,
  input logic       rst,
  input logic       scan_en,
  input logic [3:0] col_n,
  input logic [3:0] row_oe,
  input logic [3:0] key_code,
  input logic       key_valid
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (row_oe == 4'b0001 && key_code == 4'h0 && !key_valid));

  a_r2_single_row: assert property (@(posedge clk) disable iff (rst)
    $countones(row_oe) == 1);

  a_r3_still_without_pulse: assert property (@(posedge clk) disable iff (rst)
    !scan_en |=> ($stable(row_oe) && $stable(key_code) && $stable(key_valid)));

  a_r4_row_rotates: assert property (@(posedge clk) disable iff (rst)
    (scan_en && !key_valid && col_n == 4'hF) |=>
      (row_oe == {$past(row_oe[2:0]), $past(row_oe[3])}));

  a_r5_capture_sets_valid: assert property (@(posedge clk) disable iff (rst)
    (scan_en && !key_valid && col_n != 4'hF) |=> (key_valid && $stable(row_oe)));

  a_r8_hold_fixed: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> ($stable(row_oe) && $stable(key_code)));

  a_r9_no_early_release: assert property (@(posedge clk) disable iff (rst)
    (scan_en && key_valid && col_n != 4'hF) |=> key_valid);
endmodule

bind keypad_scanner keypad_scanner_chk i_keypad_scanner_chk (.*);

// File: tb/test_keypad_scanner.sv
module test_keypad_scanner;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scan_en = 1'b0;
  logic [3:0] col_n;
  logic [3:0] row_oe;
  logic [3:0] key_code;
  logic       key_valid;
  logic [15:0] pressed = '0;

  int n_run = 0;
  int n_fail = 0;

  logic [1:0] m_row = '0;
  logic       m_hold = 1'b0;
  logic       m_idle = 1'b0;
  logic [3:0] m_code = '0;

  always #4 clk = ~clk;

  keypad_scanner i_keypad_scanner (.*);

  always_comb
    for (int c = 0; c < 4; c++) begin
      col_n[c] = 1'b1;
      for (int r = 0; r < 4; r++)
        if (pressed[r*4+c] && row_oe[r]) col_n[c] = 1'b0;
    end

  function automatic logic [3:0] ref_key(input int r, input int c);
    if (r == 3) return (c == 0) ? 4'hE : (c == 1) ? 4'h0 : (c == 2) ? 4'hF : 4'hD;
    if (c == 3) return 4'(10 + r);
    return 4'(r*3 + c + 1);
  endfunction

  function automatic logic [3:0] ref_cols(input logic [1:0] r);
    logic [3:0] v = 4'hF;
    for (int c = 0; c < 4; c++) if (pressed[r*4+c]) v[c] = 1'b0;
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check({tag, " row"}, 32'(row_oe), 32'(4'b0001 << m_row));
    check({tag, " valid"}, 32'(key_valid), 32'(m_hold));
    check({tag, " code"}, 32'(key_code), 32'(m_code));
  endtask

  task automatic pulse(input string tag);
    logic [3:0] mc;
    @(negedge clk);
    mc = ref_cols(m_row);
    scan_en = 1'b1;
    if (!m_hold) begin
      if (mc != 4'hF) begin
        int lc = 3;
        for (int i = 3; i >= 0; i--) if (!mc[i]) lc = i;
        m_hold = 1'b1; m_idle = 1'b0; m_code = ref_key(int'(m_row), lc);
      end else m_row = m_row + 2'd1;
    end else if (mc != 4'hF) m_idle = 1'b0;
    else if (m_idle) begin m_hold = 1'b0; m_idle = 1'b0; end
    else m_idle = 1'b1;
    @(posedge clk);
    @(negedge clk);
    scan_en = 1'b0;
    compare(tag);
  endtask

  task automatic gap(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare(tag);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R1 reset");
    for (int i = 0; i < 9; i++) pulse("R4 idle scan");
    pressed = 16'h0001 << (2*4 + 1);
    gap(3, "R3 no pulse");
    for (int i = 0; i < 6; i++) pulse("R5 capture");
    check("R6 key 8", 32'(key_code), 32'h8);
    pressed = pressed | (16'h0001 << (0*4 + 2)) | (16'h0001 << (2*4 + 0));
    for (int i = 0; i < 3; i++) pulse("R8 hold");
    check("R2 one row", 32'($countones(row_oe)), 32'd1);
    pressed = '0;
    pulse("R9 first idle");
    pressed = 16'h0001 << (2*4 + 3);
    pulse("R9 bounce restarts");
    check("R9 still valid", 32'(key_valid), 32'd1);
    pressed = '0;
    pulse("R9 idle a");
    check("R9 held after one idle", 32'(key_valid), 32'd1);
    pulse("R9 idle b");
    check("R9 released", 32'(key_valid), 32'd0);
    for (int i = 0; i < 3; i++) pulse("R4 resume");
    pressed = (16'h0001 << (1*4 + 3)) | (16'h0001 << (1*4 + 1));
    for (int i = 0; i < 6; i++) pulse("R7 lowest column");
    check("R7 key 5", 32'(key_code), 32'h5);
    pressed = '0;
    pulse("R9"); pulse("R9");
    for (int k = 0; k < 16; k++) begin
      pressed = 16'h0001 << k;
      for (int i = 0; i < 5; i++) pulse("R6 table");
      check("R6 table code", 32'(key_code), 32'(ref_key(k / 4, k % 4)));
      pressed = '0;
      pulse("R9"); pulse("R9");
    end
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_row = '0; m_hold = 1'b0; m_idle = 1'b0; m_code = '0;
    compare("R1 second reset");
    for (int it = 0; it < 400; it++) begin
      int sel = int'($urandom_range(0, 9));
      if (sel < 5) pressed = '0;
      else if (sel < 8) pressed = 16'h0001 << $urandom_range(0, 15);
      else pressed = 16'($urandom);
      gap(int'($urandom_range(0, 3)), "R3 random gap");
      pulse("R4 R5 R8 R9 random");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule